// File: doc/BRIEF.md
# AC-Link Power State Controller

This block is the controller-side power manager of an AC'97-style serial audio link. It runs on the bit clock and walks the link through four states: a cold state with the codec held in reset, an idle state where the bit clock runs but no frame sync is produced, a running state that produces framing, and a powered-down state. It drives the active-low codec reset and the SYNC output. It samples the serial data input (SDI) on every bit clock edge so that it can tell when the codec asks to be woken up.

The way a wakeup request is recognised depends on the state. While frames run, the request is the final bit of each frame, which is bit 0 of slot 12. In every other state the request is a sustained high level on SDI. A detected request produces a one-cycle event and sets a sticky status flag, which software clears with a strobe. The link restarts framing on that request only when a restart enable is set. Frame position comes from a local bit counter, so no slot payload logic is needed.

Top module: `aclink_pwr_ctrl`

## Requirements
- R1: After reset the state output reads cold (encoding: cold=0, idle=1, running=2, powered-down=3), codec_rst_n and sync are low, and wake_evt and wake_sticky are low. The state stays cold while link_release is low.
- R2: In the cold state with link_release high, the state becomes idle one cycle later and codec_rst_n goes high. In idle, sync stays low for as long as frame_en is low.
- R3: In the idle state with frame_en high, the state becomes running on the next edge. The first running cycle is frame bit position 0. Every frame lasts 256 bit periods: sync is high for positions 0 to 15 and low for positions 16 to 255, and this repeats frame after frame.
- R4: While running, a wakeup is recognised only when SDI is high at the sampling edge of frame position 255 (bit 0 of slot 12). wake_evt is high for the one cycle after that edge. SDI at any other position produces no event.
- R5: When pdn_req is high at the edge of frame position 255, the state becomes powered-down at that frame boundary, sync stays low and codec_rst_n stays high. In the powered-down state frame_en has no effect.
- R6: Outside the running state, a wakeup is recognised when SDI is sampled high on two consecutive edges after a low sample. The event fires at the second high sample, and it fires only once for each high episode. A single high sample produces no event.
- R7: wake_sticky goes high in the same cycle as wake_evt and then holds. A one-cycle wake_clr pulse clears it. A new detection in the same cycle as the clear wins over the clear.
- R8: With wake_restart_en low, a detected wakeup only raises wake_evt and wake_sticky. The state does not change.
- R9: With wake_restart_en high, a wakeup detected in the idle or powered-down state moves the state to running on the same edge that raises wake_evt. The new frame starts at position 0 with sync high.
- R10: When link_release goes low, the state returns to cold from any state one cycle later, with codec_rst_n and sync low. Wakeups detected in the cold state are flagged but never restart the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| link_release | input | 1 | Software control: high releases the codec from cold reset |
| frame_en | input | 1 | Software control: starts frame generation from idle |
| pdn_req | input | 1 | Software powerdown command, taken at a frame boundary |
| wake_restart_en | input | 1 | Allows a detected wakeup to restart framing |
| wake_clr | input | 1 | Write-one-to-clear strobe for the sticky wakeup flag |
| sdi | input | 1 | Serial data input from the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| sync | output | 1 | Frame sync output |
| link_state | output | 2 | Current link state (0 cold, 1 idle, 2 running, 3 powered-down) |
| wake_evt | output | 1 | One-cycle pulse on a detected wakeup |
| wake_sticky | output | 1 | Sticky wakeup status flag |

## Verification
A wrong state register shows at once on link_state, and within one cycle on codec_rst_n or sync. A frame counter that is off by even one position shows within a frame: the sync high window moves or stretches, or a frame-bit wakeup lands on the wrong cycle. A level filter history that is not cleared during running shows as a wake_evt after only one high sample in powered-down. A filter that does not remember the previous sample shows as repeated events during a single high episode. Both appear within two cycles of the stimulus.

// File: rtl/aclink_pwr_pkg.sv
package aclink_pwr_pkg;

    // Link power states; encoding is visible on the link_state port.
    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2,
        ST_PDN  = 2'd3
    } link_st_e;

    // Software-side controls gathered for the state machine.
    typedef struct packed {
        logic release_rst;
        logic frame_en;
        logic pdn_req;
        logic restart_en;
    } link_ctl_s;

    // Total bit periods in one frame: tag slot plus the data slots.
    function automatic int frame_bits(input int tag_bits, input int slot_bits,
                                      input int data_slots);
        return tag_bits + slot_bits * data_slots;
    endfunction

endpackage

// File: rtl/aclink_frame_ctr.sv
module aclink_frame_ctr
    import aclink_pwr_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int DATA_SLOTS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last_bit,
    output logic sync
);
    localparam int FRAME_LEN = frame_bits(TAG_BITS, SLOT_BITS, DATA_SLOTS);
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] pos;

    // Position is held at zero outside running, so entry always starts at bit 0.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= '0;
        end else if (pos == CNT_W'(FRAME_LEN - 1)) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    assign last_bit = run && (pos == CNT_W'(FRAME_LEN - 1));
    assign sync     = run && (pos < CNT_W'(TAG_BITS));

endmodule

// File: rtl/aclink_wake_det.sv
module aclink_wake_det #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic last_bit,
    input  logic sdi,
    output logic wake
);
    // hist[0] is the previous sample; hist[FILT_LEN-1] the oldest one kept.
    logic [FILT_LEN-1:0] hist;
    logic                lvl_hit;
    logic                frm_hit;

    generate
        if (FILT_LEN > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst || run) begin
                    hist <= '0;
                end else begin
                    hist <= {hist[FILT_LEN-2:0], sdi};
                end
            end
            assign lvl_hit = !run && sdi && (&hist[FILT_LEN-2:0]) && !hist[FILT_LEN-1];
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst || run) begin
                    hist <= '0;
                end else begin
                    hist <= sdi;
                end
            end
            assign lvl_hit = !run && sdi && !hist[0];
        end
    endgenerate

    assign frm_hit = run && last_bit && sdi;
    assign wake    = lvl_hit || frm_hit;

endmodule

// File: rtl/aclink_pwr_fsm.sv
module aclink_pwr_fsm
    import aclink_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  link_ctl_s ctl,
    input  logic      last_bit,
    input  logic      wake,
    output link_st_e  state
);
    link_st_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLD: if (ctl.release_rst) nxt = ST_IDLE;
            ST_IDLE: if (ctl.frame_en || (wake && ctl.restart_en)) nxt = ST_RUN;
            ST_RUN:  if (last_bit && ctl.pdn_req) nxt = ST_PDN;
            ST_PDN:  if (wake && ctl.restart_en) nxt = ST_RUN;
            default: nxt = ST_COLD;
        endcase
        if (!ctl.release_rst) nxt = ST_COLD;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_COLD;
        else     state <= nxt;
    end

endmodule

// File: rtl/aclink_pwr_ctrl.sv
module aclink_pwr_ctrl
    import aclink_pwr_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int DATA_SLOTS = 12,
    parameter int FILT_LEN   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_release,
    input  logic       frame_en,
    input  logic       pdn_req,
    input  logic       wake_restart_en,
    input  logic       wake_clr,
    input  logic       sdi,
    output logic       codec_rst_n,
    output logic       sync,
    output logic [1:0] link_state,
    output logic       wake_evt,
    output logic       wake_sticky
);
    link_st_e  state;
    link_ctl_s ctl;
    logic      run;
    logic      last_bit;
    logic      wake;

    assign ctl = '{release_rst: link_release, frame_en: frame_en,
                   pdn_req: pdn_req, restart_en: wake_restart_en};
    assign run = (state == ST_RUN);

    aclink_frame_ctr #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .DATA_SLOTS(DATA_SLOTS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .last_bit(last_bit),
        .sync    (sync)
    );

    aclink_wake_det #(
        .FILT_LEN(FILT_LEN)
    ) u_wake (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .last_bit(last_bit),
        .sdi     (sdi),
        .wake    (wake)
    );

    aclink_pwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .last_bit(last_bit),
        .wake    (wake),
        .state   (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_evt    <= 1'b0;
            wake_sticky <= 1'b0;
        end else begin
            wake_evt    <= wake;
            wake_sticky <= wake || (wake_sticky && !wake_clr);
        end
    end

    assign codec_rst_n = (state != ST_COLD);
    assign link_state  = state;

endmodule

// File: rtl/aclink_pwr_chk.sv
module aclink_pwr_chk (
    input logic       clk,
    input logic       rst,
    input logic       pdn_req,
    input logic       wake_clr,
    input logic       codec_rst_n,
    input logic       sync,
    input logic [1:0] link_state,
    input logic       wake_evt,
    input logic       wake_sticky
);
    // R1
    cold_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd0) |-> (!codec_rst_n && !sync));

    // R2
    idle_no_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd1) |-> (!sync && codec_rst_n));

    // R3
    run_entry_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd2 && $past(link_state) != 2'd2) |-> sync);

    // R3
    sync_only_running_chk: assert property (@(posedge clk) disable iff (rst)
        sync |-> (link_state == 2'd2));

    // R5
    pdn_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd3 && $past(link_state) == 2'd2) |-> $past(pdn_req));

    // R5
    pdn_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        (link_state == 2'd3) |-> (!sync && codec_rst_n));

    // R7
    sticky_follows_evt_chk: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> wake_sticky);

    // R7
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wake_clr |=> (wake_evt || !wake_sticky));

endmodule

bind aclink_pwr_ctrl aclink_pwr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pdn_req    (pdn_req),
    .wake_clr   (wake_clr),
    .codec_rst_n(codec_rst_n),
    .sync       (sync),
    .link_state (link_state),
    .wake_evt   (wake_evt),
    .wake_sticky(wake_sticky)
);

// File: tb/aclink_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module aclink_pwr_ctrl_bench;
    localparam int FL  = 16 + 12 * 20;
    localparam int TAG = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_release = 1'b0;
    logic       frame_en = 1'b0;
    logic       pdn_req = 1'b0;
    logic       wake_restart_en = 1'b0;
    logic       wake_clr = 1'b0;
    logic       sdi = 1'b0;
    logic       codec_rst_n;
    logic       sync;
    logic [1:0] link_state;
    logic       wake_evt;
    logic       wake_sticky;

    int nchk  = 0;
    int nfail = 0;
    int fpos  = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    aclink_pwr_ctrl u_aclink_pwr_ctrl (
        .clk(clk), .rst(rst), .link_release(link_release), .frame_en(frame_en),
        .pdn_req(pdn_req), .wake_restart_en(wake_restart_en), .wake_clr(wake_clr),
        .sdi(sdi), .codec_rst_n(codec_rst_n), .sync(sync), .link_state(link_state),
        .wake_evt(wake_evt), .wake_sticky(wake_sticky)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (running) fpos = (fpos + 1) % FL;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_to(input int p);
        while (fpos != p) tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 state", link_state, 0);
        chk("R1 codec_rst_n", codec_rst_n, 0);
        chk("R1 sync", sync, 0);
        chk("R1 wake_evt", wake_evt, 0);
        chk("R1 wake_sticky", wake_sticky, 0);
        repeat (5) tick();
        chk("R1 stays cold", link_state, 0);
    endtask

    task automatic t_idle();
        link_release = 1'b1;
        tick();
        chk("R2 state idle", link_state, 1);
        chk("R2 codec_rst_n", codec_rst_n, 1);
        for (int i = 0; i < 40; i++) begin
            chk("R2 sync low in idle", sync, 0);
            tick();
        end
        chk("R2 still idle", link_state, 1);
    endtask

    task automatic t_frame();
        frame_en = 1'b1;
        tick();
        running = 1'b1;
        fpos = 0;
        chk("R3 state running", link_state, 2);
        for (int i = 0; i < FL; i++) begin
            chk("R3 sync pattern", sync, (i < TAG) ? 1 : 0);
            tick();
        end
        chk("R3 next frame sync", sync, 1);
        for (int i = 0; i < TAG + 1; i++) tick();
        chk("R3 second frame after tag", sync, 0);
    endtask

    task automatic t_run_wake();
        run_to(0);
        sdi = 1'b1;
        while (fpos != FL - 1) begin
            tick();
            chk("R4 no event mid-frame", wake_evt, 0);
        end
        sdi = 1'b0;
        tick();
        chk("R4 no event low final bit", wake_evt, 0);
        chk("R4 sticky untouched", wake_sticky, 0);
        run_to(FL - 1);
        sdi = 1'b1;
        tick();
        sdi = 1'b0;
        chk("R4 event on final bit", wake_evt, 1);
        chk("R7 sticky set", wake_sticky, 1);
        chk("R4 still running", link_state, 2);
        tick();
        chk("R4 event one cycle", wake_evt, 0);
        chk("R7 sticky holds", wake_sticky, 1);
        repeat (10) tick();
        chk("R7 sticky still holds", wake_sticky, 1);
    endtask

    task automatic t_clear();
        wake_clr = 1'b1;
        tick();
        wake_clr = 1'b0;
        chk("R7 sticky cleared", wake_sticky, 0);
    endtask

    task automatic t_pdn();
        run_to(100);
        pdn_req = 1'b1;
        run_to(FL - 1);
        chk("R5 running before boundary", link_state, 2);
        tick();
        running = 1'b0;
        pdn_req = 1'b0;
        chk("R5 powered down", link_state, 3);
        chk("R5 sync low", sync, 0);
        chk("R5 codec_rst_n high", codec_rst_n, 1);
        repeat (20) tick();
        chk("R5 frame_en ignored", link_state, 3);
        chk("R5 sync stays low", sync, 0);
    endtask

    task automatic t_level_filter();
        wake_restart_en = 1'b0;
        sdi = 1'b1;
        tick();
        sdi = 1'b0;
        chk("R6 single sample no event", wake_evt, 0);
        tick();
        chk("R6 glitch no event", wake_evt, 0);
        tick();
        chk("R6 glitch no sticky", wake_sticky, 0);
        sdi = 1'b1;
        tick();
        chk("R6 first high sample", wake_evt, 0);
        tick();
        chk("R6 second high sample event", wake_evt, 1);
        chk("R8 no restart", link_state, 3);
        chk("R8 sticky set", wake_sticky, 1);
        tick();
        chk("R6 one event per episode", wake_evt, 0);
        repeat (5) tick();
        chk("R6 held high no repeat", wake_evt, 0);
        sdi = 1'b0;
        tick();
        t_clear();
    endtask

    task automatic t_restart();
        wake_restart_en = 1'b1;
        sdi = 1'b1;
        tick();
        chk("R9 not yet", link_state, 3);
        tick();
        sdi = 1'b0;
        running = 1'b1;
        fpos = 0;
        chk("R9 restart to running", link_state, 2);
        chk("R9 event with restart", wake_evt, 1);
        chk("R9 sync at bit 0", sync, 1);
    endtask

    task automatic t_cold();
        link_release = 1'b0;
        frame_en = 1'b0;
        tick();
        running = 1'b0;
        chk("R10 back to cold", link_state, 0);
        chk("R10 codec_rst_n low", codec_rst_n, 0);
        chk("R10 sync low", sync, 0);
        t_clear();
        sdi = 1'b1;
        tick();
        tick();
        chk("R10 event in cold", wake_evt, 1);
        chk("R10 no restart from cold", link_state, 0);
        sdi = 1'b0;
        tick();
        t_clear();
        link_release = 1'b1;
        tick();
        chk("R2 idle again", link_state, 1);
        sdi = 1'b1;
        tick();
        tick();
        sdi = 1'b0;
        chk("R9 restart from idle", link_state, 2);
        chk("R9 sync from idle", sync, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_idle();
        t_frame();
        t_run_wake();
        t_clear();
        t_pdn();
        t_level_filter();
        t_restart();
        t_cold();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule